// File: doc/BRIEF.md
# Prescaled Free-Running Counter Bank

This block keeps three up-counters behind a small 32-bit register bus. Two of them are slow time bases: one advances once per second and one once per hundredth of a second. Each is paced by a free-running divider of the system clock whose divide count is a parameter, so a bench or a slower clock domain can use short divisors. The third is a cycle counter. It is paced by a 32-bit down-counter that software can see, and which reloads itself from a separate reload register each time it reaches zero.

Every counter can be read and overwritten over the bus. A write takes effect at the clock edge of the write cycle, and counting continues from the written value. The bank also holds a two-bit LED register, a two-bit button view and a seven-bit control word driven straight to output pins. Reads are combinational, so the data belongs to the address presented in the same cycle. Registers sit at fixed byte offsets because software drivers decode them.

Top module: `tick_counter_bank`

## Requirements
- R1: After synchronous reset every register reads zero, and led_out and misc_out are zero.
- R2: The seconds counter (offset 0x010) increments by one at the end of every SEC_DIV clock cycles. The first increment comes SEC_DIV cycles after reset ends, and it wraps from 0xFFFFFFFF to 0.
- R3: The hundredths counter (offset 0x014) behaves in the same way with period CENTI_DIV.
- R4: The prescale down-counter (offset 0x024) decrements by one per clock while non-zero. In a cycle where it is zero, it loads the reload register (offset 0x020) and the cycle counter (offset 0x018) increments by one, so a reload value N gives one increment every N+1 clocks.
- R5: With a reload value of zero, the cycle counter increments on every clock.
- R6: A bus write to any of the three counters or to the prescale down-counter loads the written data at that edge. This holds even when the same edge would have advanced it, and counting resumes from the new value afterwards.
- R7: The LED register (offset 0x000) stores write data bits [1:0] and drives them on led_out. Bits [31:2] read as zero.
- R8: The button register (offset 0x008) reads the btn_in pins in bits [1:0], with zero above. Writes to it change nothing.
- R9: The control register (offset 0x04C) stores write data bits [6:0] except bit 2, which always reads and drives zero. The stored bits drive misc_out, and bits [31:7] read as zero.
- R10: A read of any other byte offset, including a misaligned one, returns zero, and a write there changes no register.
- R11: A cycle with bus_we high but bus_en low changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write qualifier, used with bus_en |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| btn_in | input | 2 | Button pin levels |
| led_out | output | 2 | LED register bits |
| misc_out | output | 7 | Control word bits, bit 2 held low |

## Verification
The collision that matters is a software write landing on the same edge as a counter's own advance. That can be a seconds or hundredths tick, or a prescale zero-hit that both reloads the down-counter and bumps the cycle counter. The bench provokes it by writing the counters on consecutive cycles across a stretch long enough to cover several divider ticks and zero-hits. The behavioural model gives the write priority, and the register read back on the next cycle must equal the written value, not that value plus one. The same stretch confirms that the cycle counter still advances when the write hits only the down-counter at its zero.

// File: rtl/tick_bank_pkg.sv
package tick_bank_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 12;

    // Byte offsets decoded by software drivers
    localparam logic [ADDR_W-1:0] OFS_LED    = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_BTN    = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_SEC    = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_CENTI  = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_CYC    = 12'h018;
    localparam logic [ADDR_W-1:0] OFS_RELOAD = 12'h020;
    localparam logic [ADDR_W-1:0] OFS_PSC    = 12'h024;
    localparam logic [ADDR_W-1:0] OFS_MISC   = 12'h04C;

    localparam int unsigned LED_W  = 2;
    localparam int unsigned MISC_W = 7;
    localparam logic [MISC_W-1:0] MISC_KEEP = 7'b111_1011;

    typedef enum logic [3:0] {
        SEL_LED, SEL_BTN, SEL_SEC, SEL_CENTI, SEL_CYC,
        SEL_RELOAD, SEL_PSC, SEL_MISC, SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic              reload;
        logic              psc;
        logic              cyc;
        logic [DATA_W-1:0] data;
    } psc_wr_t;

    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_LED:    s = SEL_LED;
            OFS_BTN:    s = SEL_BTN;
            OFS_SEC:    s = SEL_SEC;
            OFS_CENTI:  s = SEL_CENTI;
            OFS_CYC:    s = SEL_CYC;
            OFS_RELOAD: s = SEL_RELOAD;
            OFS_PSC:    s = SEL_PSC;
            OFS_MISC:   s = SEL_MISC;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pulse_divider.sv
module pulse_divider #(
    parameter int unsigned DIVIDE = 10
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned W = $clog2(DIVIDE > 1 ? DIVIDE : 2);
    localparam logic [W-1:0] LAST = W'(DIVIDE - 1);

    logic [W-1:0] count_q;

    assign tick = (count_q == LAST);

    always_ff @(posedge clk) begin
        if (rst)
            count_q <= '0;
        else if (tick)
            count_q <= '0;
        else
            count_q <= count_q + 1'b1;
    end
endmodule

// File: rtl/prescale_engine.sv
module prescale_engine
    import tick_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  psc_wr_t           wr,
    output logic [DATA_W-1:0] reload_q,
    output logic [DATA_W-1:0] psc_q,
    output logic [DATA_W-1:0] cyc_q
);
    logic zero_hit;

    assign zero_hit = (psc_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
            psc_q    <= '0;
            cyc_q    <= '0;
        end else begin
            if (wr.reload)
                reload_q <= wr.data;

            if (wr.psc)
                psc_q <= wr.data;
            else if (zero_hit)
                psc_q <= reload_q;
            else
                psc_q <= psc_q - 1'b1;

            if (wr.cyc)
                cyc_q <= wr.data;
            else if (zero_hit)
                cyc_q <= cyc_q + 1'b1;
        end
    end
endmodule

// File: rtl/tick_counter_bank.sv
module tick_counter_bank
    import tick_bank_pkg::*;
#(
    parameter int unsigned SEC_DIV   = 125_000_000,
    parameter int unsigned CENTI_DIV = 1_250_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [LED_W-1:0]  btn_in,
    output logic [LED_W-1:0]  led_out,
    output logic [MISC_W-1:0] misc_out
);
    localparam int unsigned NUM_SLOW = 2;
    localparam int unsigned DIV_LIST [NUM_SLOW] = '{SEC_DIV, CENTI_DIV};
    localparam reg_sel_e    SEL_LIST [NUM_SLOW] = '{SEL_SEC, SEL_CENTI};

    reg_sel_e          sel;
    logic              wr;
    logic              tick_w [NUM_SLOW];
    logic [DATA_W-1:0] slow_q [NUM_SLOW];
    logic [DATA_W-1:0] reload_q, psc_q, cyc_q;
    logic [LED_W-1:0]  led_q;
    logic [MISC_W-1:0] misc_q;
    psc_wr_t           pwr;

    assign sel = decode_sel(bus_addr);
    assign wr  = bus_en & bus_we;

    for (genvar g = 0; g < NUM_SLOW; g++) begin : g_slow
        pulse_divider #(.DIVIDE(DIV_LIST[g])) u_div (
            .clk  (clk),
            .rst  (rst),
            .tick (tick_w[g])
        );

        always_ff @(posedge clk) begin
            if (rst)
                slow_q[g] <= '0;
            else if (wr && sel == SEL_LIST[g])
                slow_q[g] <= bus_wdata;
            else if (tick_w[g])
                slow_q[g] <= slow_q[g] + 1'b1;
        end
    end

    always_comb begin
        pwr.reload = wr && (sel == SEL_RELOAD);
        pwr.psc    = wr && (sel == SEL_PSC);
        pwr.cyc    = wr && (sel == SEL_CYC);
        pwr.data   = bus_wdata;
    end

    prescale_engine u_psc (
        .clk      (clk),
        .rst      (rst),
        .wr       (pwr),
        .reload_q (reload_q),
        .psc_q    (psc_q),
        .cyc_q    (cyc_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            led_q  <= '0;
            misc_q <= '0;
        end else if (wr) begin
            if (sel == SEL_LED)
                led_q <= bus_wdata[LED_W-1:0];
            if (sel == SEL_MISC)
                misc_q <= bus_wdata[MISC_W-1:0] & MISC_KEEP;
        end
    end

    assign led_out  = led_q;
    assign misc_out = misc_q;

    always_comb begin
        case (sel)
            SEL_LED:    bus_rdata = {{(DATA_W-LED_W){1'b0}}, led_q};
            SEL_BTN:    bus_rdata = {{(DATA_W-LED_W){1'b0}}, btn_in};
            SEL_SEC:    bus_rdata = slow_q[0];
            SEL_CENTI:  bus_rdata = slow_q[1];
            SEL_CYC:    bus_rdata = cyc_q;
            SEL_RELOAD: bus_rdata = reload_q;
            SEL_PSC:    bus_rdata = psc_q;
            SEL_MISC:   bus_rdata = {{(DATA_W-MISC_W){1'b0}}, misc_q};
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tick_counter_bank_chk.sv
module tick_counter_bank_chk
    import tick_bank_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [MISC_W-1:0] misc_out,
    input logic              sec_tick,
    input logic [DATA_W-1:0] sec,
    input logic [DATA_W-1:0] reload,
    input logic [DATA_W-1:0] psc,
    input logic [DATA_W-1:0] cyc
);
    logic wr, wr_sec, wr_psc, wr_cyc, wr_misc, mapped;

    assign wr      = bus_en && bus_we;
    assign wr_sec  = wr && bus_addr == OFS_SEC;
    assign wr_psc  = wr && bus_addr == OFS_PSC;
    assign wr_cyc  = wr && bus_addr == OFS_CYC;
    assign wr_misc = wr && bus_addr == OFS_MISC;
    assign mapped  = bus_addr inside {OFS_LED, OFS_BTN, OFS_SEC, OFS_CENTI,
                                      OFS_CYC, OFS_RELOAD, OFS_PSC, OFS_MISC};

    p_sec_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!wr_sec && !sec_tick) |=> $stable(sec));

    p_psc_down_r4: assert property (@(posedge clk) disable iff (rst)
        (!wr_psc && psc != '0) |=> psc == $past(psc) - 1);

    p_psc_reload_r4: assert property (@(posedge clk) disable iff (rst)
        (!wr_psc && psc == '0) |=> psc == $past(reload));

    p_cyc_step_r4: assert property (@(posedge clk) disable iff (rst)
        (!wr_cyc && psc == '0) |=> cyc == $past(cyc) + 1);

    p_write_wins_r6: assert property (@(posedge clk) disable iff (rst)
        wr_sec |=> sec == $past(bus_wdata));

    p_misc_load_r9: assert property (@(posedge clk) disable iff (rst)
        wr_misc |=> misc_out == ($past(bus_wdata[MISC_W-1:0]) & MISC_KEEP));

    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
        !mapped |-> bus_rdata == '0);
endmodule

bind tick_counter_bank tick_counter_bank_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .misc_out  (misc_out),
    .sec_tick  (tick_w[0]),
    .sec       (slow_q[0]),
    .reload    (reload_q),
    .psc       (psc_q),
    .cyc       (cyc_q)
);

// File: tb/tick_counter_bank_tb_top.sv
module tick_counter_bank_tb_top;
    localparam int SD = 20;
    localparam int CD = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = 12'h000;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  btn_in = 2'b00;
    logic [1:0]  led_out;
    logic [6:0]  misc_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    string phase = "R1";

    // behavioural reference state (after the most recent edge)
    int       m_sd = 0, m_cd = 0;
    bit [31:0] m_sec = 0, m_cen = 0, m_cyc = 0, m_rel = 0, m_psc = 0;
    bit [1:0]  m_led = 0;
    bit [6:0]  m_misc = 0;

    always #4 clk = ~clk;

    tick_counter_bank #(.SEC_DIV(SD), .CENTI_DIV(CD)) dut_i (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .btn_in(btn_in), .led_out(led_out), .misc_out(misc_out)
    );

    function automatic string reg_tag(input logic [11:0] a);
        case (a)
            12'h000: return "R7";
            12'h008: return "R8";
            12'h010: return "R2";
            12'h014: return "R3";
            12'h018, 12'h020, 12'h024: return "R4";
            12'h04C: return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic bit [31:0] model_read(input logic [11:0] a);
        case (a)
            12'h000: return {30'b0, m_led};
            12'h008: return {30'b0, btn_in};
            12'h010: return m_sec;
            12'h014: return m_cen;
            12'h018: return m_cyc;
            12'h020: return m_rel;
            12'h024: return m_psc;
            12'h04C: return {25'b0, m_misc};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input bit [31:0] act, input bit [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s/%s at %0t: actual 0x%08h expected 0x%08h", tag, phase, $time, act, exp);
        end
    endtask

    task automatic compare();
        bit [31:0] e;
        e = model_read(bus_addr);
        check(bus_rdata === e, reg_tag(bus_addr), bus_rdata, e);
        check(led_out === m_led, "R7", {30'b0, led_out}, {30'b0, m_led});
        check(misc_out === m_misc, "R9", {25'b0, misc_out}, {25'b0, m_misc});
    endtask

    task automatic model_step(input bit r, input bit e, input bit w, input logic [11:0] a, input bit [31:0] d);
        bit st, ct, zh, we;
        if (r) begin
            m_sd = 0; m_cd = 0; m_sec = 0; m_cen = 0; m_cyc = 0;
            m_rel = 0; m_psc = 0; m_led = 0; m_misc = 0;
            return;
        end
        we = e && w;
        st = (m_sd == SD - 1);
        ct = (m_cd == CD - 1);
        zh = (m_psc == 0);
        m_sd = st ? 0 : m_sd + 1;
        m_cd = ct ? 0 : m_cd + 1;
        m_sec = (we && a == 12'h010) ? d : m_sec + 32'(st);
        m_cen = (we && a == 12'h014) ? d : m_cen + 32'(ct);
        m_cyc = (we && a == 12'h018) ? d : m_cyc + 32'(zh);
        m_psc = (we && a == 12'h024) ? d : (zh ? m_rel : m_psc - 1);
        if (we && a == 12'h020) m_rel = d;
        if (we && a == 12'h000) m_led = d[1:0];
        if (we && a == 12'h04C) m_misc = d[6:0] & 7'b1111011;
    endtask

    task automatic step(input bit r, input bit e, input bit w, input logic [11:0] a, input bit [31:0] d);
        @(negedge clk);
        compare();
        rst = r; bus_en = e; bus_we = w; bus_addr = a; bus_wdata = d;
        model_step(r, e, w, a, d);
    endtask

    logic [11:0] rot [12] = '{12'h000, 12'h008, 12'h010, 12'h014, 12'h018, 12'h020,
                              12'h024, 12'h04C, 12'h004, 12'h030, 12'hFFC, 12'h011};
    int rot_i = 0;

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            step(0, 0, 0, rot[rot_i], 32'h0);
            rot_i = (rot_i + 1) % 12;
        end
    endtask

    initial begin
        // R1: reset state, held for a few edges
        for (int i = 0; i < 3; i++) step(1, 0, 0, rot[i + 2], 32'h0);
        idle(8);
        // R5: reload zero, cycle counter steps every clock; R2/R3 ticks
        phase = "R5";
        idle(60);
        // R4: reload value and explicit down-counter load
        phase = "R4";
        step(0, 1, 1, 12'h020, 32'd3);
        idle(40);
        step(0, 1, 1, 12'h024, 32'd10);
        idle(30);
        // R6: writes on consecutive cycles collide with ticks and zero-hits
        phase = "R6";
        for (int i = 0; i < 24; i++) begin
            step(0, 1, 1, 12'h010, 32'hFFFF_FFF0 + 32'(i));
            step(0, 1, 1, 12'h014, 32'h100 + 32'(i));
            step(0, 1, 1, 12'h018, 32'h1000 + 32'(i));
            step(0, 1, 1, 12'h024, 32'(i % 3));
        end
        idle(40);
        // R7, R8, R9: small registers
        phase = "R7";
        step(0, 1, 1, 12'h000, 32'hFFFF_FFFF);
        idle(12);
        step(0, 1, 1, 12'h000, 32'h0000_0002);
        idle(12);
        phase = "R8";
        btn_in = 2'b01;
        step(0, 1, 1, 12'h008, 32'hFFFF_FFFF);
        idle(12);
        btn_in = 2'b10;
        idle(12);
        phase = "R9";
        step(0, 1, 1, 12'h04C, 32'hFFFF_FFFF);
        idle(12);
        step(0, 1, 1, 12'h04C, 32'h0000_0055);
        idle(12);
        // R10: unmapped and misaligned writes
        phase = "R10";
        step(0, 1, 1, 12'h004, 32'hFFFF_FFFF);
        step(0, 1, 1, 12'h030, 32'hFFFF_FFFF);
        step(0, 1, 1, 12'h011, 32'hFFFF_FFFF);
        step(0, 1, 1, 12'h026, 32'hFFFF_FFFF);
        idle(24);
        // R11: write qualifier without strobe
        phase = "R11";
        step(0, 0, 1, 12'h000, 32'h0000_0001);
        step(0, 0, 1, 12'h010, 32'h1234_5678);
        step(0, 0, 1, 12'h04C, 32'h0000_0000);
        step(0, 0, 1, 12'h020, 32'h0000_0000);
        idle(24);
        // R1 again: reset mid-run
        phase = "R1";
        step(1, 0, 0, 12'h010, 32'h0);
        step(1, 0, 0, 12'h018, 32'h0);
        idle(24);
        @(negedge clk);
        compare();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule